// File: doc/BRIEF.md
# Receive FIFO with Line Status

This block holds received characters between the serial receiver and the CPU, and builds the 8-bit line status byte that software reads. Every entry carries the character together with three error tags (parity, framing, break) and a ninth data bit. The receiver writes one entry per completed character through a single-cycle push strobe. The CPU pops the oldest entry with a data-read strobe and reads the status byte with a status-read strobe.

The parity, framing and break flags describe the entry at the head of the FIFO, not the most recently received one. A flag is raised when a tagged entry becomes the head and stays raised until software reads the status byte. A summary error bit records that some tagged character was written, and a status read clears it. A legacy mode holds the summary bit at 0. In nine-bit mode the parity flag position instead shows the ninth data bit of the head entry. Two transmitter status inputs are passed through into the upper bits.

Top module: `rx_line_status_fifo`

## Requirements
- R1: status bit 0 is 1 exactly when the FIFO holds at least one entry. It updates on the cycle after the push or pop that changes the occupancy.
- R2: a push while the FIFO holds DEPTH entries is discarded and the stored entries are kept. Status bit 1 (overrun) is 1 from the next cycle on. It clears on the cycle after a status read, unless another discarded push occurs in the same cycle as that read.
- R3: entries leave in the order they were written. rd_data_o shows the data of the head entry, and a data-read strobe removes that entry. A push and a pop in the same cycle are both performed when the FIFO is neither empty nor full. When it is full the push is discarded.
- R4: status bits 2 (parity), 3 (framing) and 4 (break) are set on the cycle after an entry with that tag becomes the head. An entry becomes the head when it is pushed into an empty FIFO, or when the entry ahead of it is popped. The bits stay set through later pops until a status read clears them. An arrival in the same cycle as the read takes precedence over the read.
- R5: status bit 5 equals tx_fifo_empty_i, and status bit 6 equals tx_fifo_empty_i AND tx_shift_empty_i, with no delay.
- R6: status bit 7 is set on the cycle after an accepted push carrying any error tag. It is cleared by a status read, and a tagged write in the same cycle takes precedence over the read.
- R7: while legacy_i is 1, status bit 7 reads 0, and no tagged write made during that time sets it later.
- R8: while nine_bit_i is 1, status bit 2 shows the ninth data bit of the head entry (0 when the FIFO is empty). A parity tag pushed while nine_bit_i is 1 is discarded, so it affects neither bit 2 nor bit 7 later.
- R9: a data-read strobe while the FIFO is empty has no effect on the contents or on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Receiver has completed a character (one cycle) |
| push_data_i | input | 8 | Character data |
| push_bit9_i | input | 1 | Ninth data bit of the character |
| push_perr_i | input | 1 | Character failed its parity check |
| push_ferr_i | input | 1 | Character had a bad stop bit |
| push_brk_i | input | 1 | Character is a break indication |
| nine_bit_i | input | 1 | Nine-bit framing mode |
| legacy_i | input | 1 | Legacy mode: summary error bit held at 0 |
| rd_data_i | input | 1 | CPU data read: pop the head entry |
| rd_status_i | input | 1 | CPU status read: clear the read-sensitive bits |
| tx_fifo_empty_i | input | 1 | Transmit FIFO is empty |
| tx_shift_empty_i | input | 1 | Transmit shift register is empty |
| rd_data_o | output | 8 | Data of the head entry |
| status_o | output | 8 | Line status byte |

## Verification
The assertions assume that the strobes and mode inputs are known, 0-or-1 values on every clock edge after reset. They also assume that any strobe may occur in any cycle, including together with the others and in either mode. They do not assume that software avoids popping an empty FIFO or pushing into a full one, so those cases are legal stimulus. The bench changes inputs only at the falling edge. It mixes directed sequences (fill past full, tagged heads, a read at the same moment as an arrival, mode flips while entries are queued) with a long stretch of random traffic whose push and pop rates drive the FIFO to both full and empty.

// File: rtl/rxls_pkg.sv
package rxls_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned STAT_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int unsigned TAG_N = 3;  // perr, ferr, brk -> status bits 2..4
endpackage

// File: rtl/rxls_fifo_store.sv
module rxls_fifo_store
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  rx_entry_t        wr_entry_i,
  input  logic             rd_en_i,
  output rx_entry_t        head_o,
  output rx_entry_t        next_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr] <= wr_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en_i) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_en_i) rd_ptr <= ptr_inc(rd_ptr);
      unique case ({wr_en_i, rd_en_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign next_o  = mem[ptr_inc(rd_ptr)];  // lookahead for head change on pop
  assign count_o = count;
endmodule

// File: rtl/rxls_status_regs.sv
module rxls_status_regs
  import rxls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              status_rd_i,
  input  logic              arrive_i,
  input  rx_entry_t         arrive_entry_i,
  input  logic              accept_bad_i,
  input  logic              drop_i,
  input  logic              legacy_i,
  input  logic              nine_bit_i,
  input  logic              nonempty_i,
  input  logic              head_bit9_i,
  input  logic              tx_fifo_empty_i,
  input  logic              tx_shift_empty_i,
  output logic [STAT_W-1:0] status_o
);
  logic [TAG_N-1:0] tag_in;
  logic [TAG_N-1:0] tag_q;
  logic             ovr_q;
  logic             err_q;

  assign tag_in = {arrive_entry_i.brk, arrive_entry_i.ferr, arrive_entry_i.perr};

  for (genvar i = 0; i < TAG_N; i++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  tag_q[i] <= 1'b0;
      else if (arrive_i && tag_in[i]) tag_q[i] <= 1'b1;
      else if (status_rd_i)         tag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (drop_i)           ovr_q <= 1'b1;
      else if (status_rd_i) ovr_q <= 1'b0;

      if (legacy_i)          err_q <= 1'b0;
      else if (accept_bad_i) err_q <= 1'b1;
      else if (status_rd_i)  err_q <= 1'b0;
    end
  end

  always_comb begin
    status_o    = '0;
    status_o[0] = nonempty_i;
    status_o[1] = ovr_q;
    status_o[2] = nine_bit_i ? (nonempty_i & head_bit9_i) : tag_q[0];
    status_o[3] = tag_q[1];
    status_o[4] = tag_q[2];
    status_o[5] = tx_fifo_empty_i;
    status_o[6] = tx_fifo_empty_i & tx_shift_empty_i;
    status_o[7] = err_q & ~legacy_i;
  end
endmodule

// File: rtl/rx_line_status_fifo.sv
module rx_line_status_fifo
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_bit9_i,
  input  logic              push_perr_i,
  input  logic              push_ferr_i,
  input  logic              push_brk_i,
  input  logic              nine_bit_i,
  input  logic              legacy_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  input  logic              tx_fifo_empty_i,
  input  logic              tx_shift_empty_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] status_o
);
  rx_entry_t        wr_entry, head, next_entry, arrive_entry;
  logic [CNT_W-1:0] fifo_count;
  logic             full, empty, one_left;
  logic             push_ok, drop, pop, arrive, accept_bad;

  assign full     = (fifo_count == CNT_W'(DEPTH));
  assign empty    = (fifo_count == '0);
  assign one_left = (fifo_count == CNT_W'(1));

  assign push_ok = push_i & ~full;
  assign drop    = push_i & full;
  assign pop     = rd_data_i & ~empty;

  // parity tag has no meaning in nine-bit framing: dropped at write
  assign wr_entry = '{brk:  push_brk_i,
                      ferr: push_ferr_i,
                      perr: push_perr_i & ~nine_bit_i,
                      bit9: push_bit9_i,
                      data: push_data_i};

  assign accept_bad = push_ok & (wr_entry.perr | wr_entry.ferr | wr_entry.brk);

  assign arrive = (push_ok & empty) | (pop & ~one_left) | (pop & one_left & push_ok);
  assign arrive_entry = (empty || one_left) ? wr_entry : next_entry;

  rxls_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (push_ok),
    .wr_entry_i (wr_entry),
    .rd_en_i    (pop),
    .head_o     (head),
    .next_o     (next_entry),
    .count_o    (fifo_count)
  );

  rxls_status_regs u_status (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .status_rd_i      (rd_status_i),
    .arrive_i         (arrive),
    .arrive_entry_i   (arrive_entry),
    .accept_bad_i     (accept_bad),
    .drop_i           (drop),
    .legacy_i         (legacy_i),
    .nine_bit_i       (nine_bit_i),
    .nonempty_i       (~empty),
    .head_bit9_i      (head.bit9),
    .tx_fifo_empty_i  (tx_fifo_empty_i),
    .tx_shift_empty_i (tx_shift_empty_i),
    .status_o         (status_o)
  );

  assign rd_data_o = head.data;
endmodule

// File: rtl/rxls_checker.sv
module rxls_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             rd_data_i,
  input logic             rd_status_i,
  input logic             legacy_i,
  input logic [7:0]       status_o,
  input logic [CNT_W-1:0] fifo_count
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CNT_W'(DEPTH));

  a_r2_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && fifo_count == CNT_W'(DEPTH) |=> status_o[1]);

  a_r2_keep_contents: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !rd_data_i && fifo_count == CNT_W'(DEPTH) |=> fifo_count == CNT_W'(DEPTH));

  a_r1_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !push_i && fifo_count == CNT_W'(1) |=> !status_o[0]);

  a_r6_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i && !push_i |=> !status_o[7]);

  a_r7_legacy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |-> !status_o[7]);

  a_r5_idle_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> status_o[5]);

  a_r9_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !push_i && fifo_count == '0 |=> fifo_count == '0 && !status_o[0]);
endmodule

bind rx_line_status_fifo rxls_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .rd_data_i   (rd_data_i),
  .rd_status_i (rd_status_i),
  .legacy_i    (legacy_i),
  .status_o    (status_o),
  .fifo_count  (fifo_count)
);

// File: tb/rx_line_status_fifo_bench.sv
module rx_line_status_fifo_bench;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 0, push_bit9_i = 0, push_perr_i = 0, push_ferr_i = 0, push_brk_i = 0;
  logic [7:0] push_data_i = '0;
  logic       nine_bit_i = 0, legacy_i = 0, rd_data_i = 0, rd_status_i = 0;
  logic       tx_fifo_empty_i = 1, tx_shift_empty_i = 1;
  logic [7:0] rd_data_o, status_o;

  rx_line_status_fifo #(.DEPTH(DEPTH)) u_rx_line_status_fifo (.*);

  always #4 clk_i = ~clk_i;

  // model entry: {brk, ferr, perr, bit9, data}
  logic [11:0] q[$];
  logic m_ovr = 0, m_pf = 0, m_ff = 0, m_bf = 0, m_err = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "reset";

  function automatic string req_of(int b);
    case (b)
      0: return "R1";
      1: return "R2";
      2: return nine_bit_i ? "R8" : "R4";
      3, 4: return "R4";
      5, 6: return "R5";
      default: return legacy_i ? "R7" : "R6";
    endcase
  endfunction

  task automatic model_step(input logic p, input logic [7:0] d, input logic b9, pe, fe, bk,
                            input logic rdd, rds);
    bit pre_empty = (q.size() == 0);
    bit full = (q.size() == DEPTH);
    bit ok = p && !full;
    bit pop = rdd && !pre_empty;
    bit arrive;
    logic gpe = pe & ~nine_bit_i;
    if (pop) void'(q.pop_front());
    if (ok) q.push_back({bk, fe, gpe, b9, d});
    arrive = (pop && q.size() > 0) || (pre_empty && ok);
    if (rds) begin m_pf = 0; m_ff = 0; m_bf = 0; m_ovr = 0; m_err = 0; end
    if (arrive) begin
      if (q[0][9])  m_pf = 1;
      if (q[0][10]) m_ff = 1;
      if (q[0][11]) m_bf = 1;
    end
    if (p && full) m_ovr = 1;
    if (ok && (gpe || fe || bk)) m_err = 1;
    if (legacy_i) m_err = 0;
  endtask

  task automatic compare();
    logic [7:0] exp;
    bit bad = 0;
    exp[0] = q.size() > 0;
    exp[1] = m_ovr;
    exp[2] = nine_bit_i ? (q.size() > 0 && q[0][8]) : m_pf;
    exp[3] = m_ff;
    exp[4] = m_bf;
    exp[5] = tx_fifo_empty_i;
    exp[6] = tx_fifo_empty_i & tx_shift_empty_i;
    exp[7] = m_err & ~legacy_i;
    checks++;
    for (int b = 0; b < 8; b++)
      if (status_o[b] !== exp[b]) begin
        bad = 1;
        $display("FAIL %s [%s] status bit %0d actual=%b expected=%b", req_of(b), phase, b,
                 status_o[b], exp[b]);
      end
    if (bad) fails++;
    if (q.size() > 0) begin
      checks++;
      if (rd_data_o !== q[0][7:0]) begin
        fails++;
        $display("FAIL R3 [%s] head data actual=%h expected=%h", phase, rd_data_o, q[0][7:0]);
      end
    end
  endtask

  task automatic step(input logic p = 0, input logic [7:0] d = 0, input logic b9 = 0,
                      input logic pe = 0, input logic fe = 0, input logic bk = 0,
                      input logic rdd = 0, input logic rds = 0);
    push_i = p; push_data_i = d; push_bit9_i = b9; push_perr_i = pe;
    push_ferr_i = fe; push_brk_i = bk; rd_data_i = rdd; rd_status_i = rds;
    @(posedge clk_i);
    model_step(p, d, b9, pe, fe, bk, rdd, rds);
    @(negedge clk_i);
    compare();
    push_i = 0; rd_data_i = 0; rd_status_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare();                                   // reset state, R1/R5
    phase = "R3 order";
    for (int i = 0; i < 5; i++) step(.p(1), .d(8'h10 + 8'(i)));
    step(.p(1), .d(8'hA5), .rdd(1));             // simultaneous push/pop
    for (int i = 0; i < 6; i++) step(.rdd(1));
    phase = "R4 head flags";
    step(.p(1), .d(8'h01));
    step(.p(1), .d(8'h02), .pe(1));
    step(.p(1), .d(8'h03), .fe(1));
    step(.p(1), .d(8'h04), .bk(1));
    step(.rds(1));                               // clears R6 summary bit
    step(.rdd(1));                               // parity entry to head
    step(.rdd(1), .rds(1));                      // arrival beats read
    step(.rds(1));
    step(.rdd(1));
    step(.rds(1));
    step(.rdd(1));
    step(.rdd(1));
    phase = "R9 empty read";
    step(.rdd(1));
    step(.rdd(1), .rds(1));
    phase = "R2 overrun";
    for (int i = 0; i < DEPTH; i++) step(.p(1), .d(8'(i * 7)));
    step(.p(1), .d(8'hEE), .fe(1));
    step(.p(1), .d(8'hEF), .rdd(1));             // full: push dropped, pop done
    step(.rds(1));
    step();
    for (int i = 0; i < DEPTH; i++) step(.rdd(1));
    phase = "R7 legacy";
    legacy_i = 1;
    step(.p(1), .d(8'h55), .bk(1));
    legacy_i = 0;
    step();
    step(.rdd(1), .rds(1));
    phase = "R8 nine-bit";
    nine_bit_i = 1;
    step(.p(1), .d(8'h66), .b9(1), .pe(1));
    step(.p(1), .d(8'h67), .b9(0));
    step(.rdd(1));
    nine_bit_i = 0;
    step(.rdd(1));
    phase = "R5 tx";
    tx_fifo_empty_i = 0; step();
    tx_shift_empty_i = 0; step();
    tx_fifo_empty_i = 1; step();
    tx_shift_empty_i = 1; step();
    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 64) == 0) nine_bit_i = ~nine_bit_i;
      if (($urandom % 64) == 0) legacy_i = ~legacy_i;
      tx_fifo_empty_i = 1'($urandom);
      tx_shift_empty_i = 1'($urandom);
      step(.p(($urandom % 100) < ((n / 500) % 2 ? 70 : 35)), .d(8'($urandom)),
           .b9(1'($urandom)), .pe(($urandom % 5) == 0), .fe(($urandom % 6) == 0),
           .bk(($urandom % 9) == 0), .rdd(($urandom % 100) < 50),
           .rds(($urandom % 5) == 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule